// File: doc/BRIEF.md
# Aging Counter Replacement Selector

This block picks a page frame to evict. It approximates least-recently-used ordering with a small history register for each frame. Each frame has a referenced flag and an age counter. A reference strobe for a frame sets that frame's flag. On every periodic tick, each counter moves its history one place toward the least significant end, and the frame's flag enters at the top. All flags are then cleared. A frame used in recent intervals therefore holds a large counter, and a frame left idle sees its counter decay toward zero.

When a victim is requested, the block reports the frame whose counter is smallest. The result appears one cycle after the request. Another block produces the tick and carries out the eviction.

Top module: `age_replace_sel`

## Requirements
- R1: After a synchronous active-low reset, every counter and every referenced flag is zero, so a victim request returns frame 0, and `victim_vld` is low until the first request.
- R2: A strobe on bit k of `ref_strb` sets frame k's referenced flag. The flag stays set until the next tick, however many further strobes arrive.
- R3: On a tick, each counter shifts right by one bit and takes the frame's referenced flag in its most significant bit.
- R4: Every referenced flag is cleared by a tick. A frame that is not referenced again gets 0 in the MSB at the following tick, and its counter reaches zero after `AGE_W` such ticks.
- R5: A strobe in the same cycle as a tick is not used by that tick. It sets the flag for the next interval.
- R6: The victim is the frame with the numerically smallest counter. When counters are equal, the lowest frame index wins.
- R7: `victim_vld` is high in exactly the cycle after `victim_req`. `victim_idx` then reflects the counters as they stood before any tick in the request cycle.
- R8: Counters do not change in cycles without a tick, whatever the reference strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_strb | input | NUM_FRAMES | Per-frame reference strobe |
| tick | input | 1 | Periodic aging tick |
| victim_req | input | 1 | Request for a victim frame |
| victim_vld | output | 1 | Victim result valid, one cycle after the request |
| victim_idx | output | IDX_W | Index of the selected victim frame |

## Verification
The hardest situations to reach from the ports combine a tick with other events in the same cycle. In one, a reference arrives together with a tick. In the other, a victim request arrives together with a tick. Neither counter nor flag is visible directly, so the bench keeps its own model of every frame. It drives these coincident cycles on purpose and follows each with requests whose answer is different only if the same-cycle reference or the pre-tick sampling was handled wrongly. The stimulus also aligns counters to produce ties and lets a frame decay for a full counter width to expose the clearing of the flags.

// File: rtl/age_sel_pkg.sv
// Package: shared defaults and helpers for the aging replacement selector.
// Assumes frame counts of at least two.
package age_sel_pkg;
    localparam int DEF_FRAMES = 6;
    localparam int DEF_AGE_W  = 8;

    // Width of an index able to name n frames (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/age_frame_slot.sv
// Module: one frame's referenced flag and age counter.
// Assumes ref_i and tick_i are synchronous single-cycle strobes.
module age_frame_slot #(
    parameter int AGE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic             tick_i,
    output logic [AGE_W-1:0] age_o
);
    logic             r_bit;
    logic [AGE_W-1:0] age_q;

    // Age on tick; latch reference flag (same-cycle reference belongs to next interval).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_bit <= 1'b0;
            age_q <= '0;
        end else if (tick_i) begin
            age_q <= {r_bit, age_q[AGE_W-1:1]};
            r_bit <= ref_i;
        end else if (ref_i) begin
            r_bit <= 1'b1;
        end
    end

    assign age_o = age_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (age_q == '0) && !r_bit);
    // R3
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (age_q[AGE_W-1] == $past(r_bit)) && (age_q[AGE_W-2:0] == $past(age_q[AGE_W-1:1])));
    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ref_i) |=> !r_bit);
    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_i |=> r_bit);
    // R8
    age_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(age_q));
endmodule

// File: rtl/age_min_pick.sv
// Module: finds the smallest counter among all frames; the lowest index wins ties.
// Assumes ages are packed with frame 0 in the least significant slice.
module age_min_pick #(
    parameter int NUM_FRAMES = 6,
    parameter int AGE_W      = 8,
    parameter int IDX_W      = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_FRAMES*AGE_W-1:0] ages_i,
    output logic [IDX_W-1:0]            min_idx_o,
    output logic [AGE_W-1:0]            min_age_o
);
    // Linear scan with strict compare so earlier frames keep ties.
    always_comb begin
        min_age_o = ages_i[AGE_W-1:0];
        min_idx_o = '0;
        for (int k = 1; k < NUM_FRAMES; k++) begin
            if (ages_i[k*AGE_W +: AGE_W] < min_age_o) begin
                min_age_o = ages_i[k*AGE_W +: AGE_W];
                min_idx_o = IDX_W'(k);
            end
        end
    end

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_chk
        // R6
        min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            min_age_o <= ages_i[g*AGE_W +: AGE_W]);
        // R6
        tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ages_i[g*AGE_W +: AGE_W] == min_age_o) |-> (int'(min_idx_o) <= g));
    end
endmodule

// File: rtl/age_replace_sel.sv
// Module: aging-counter victim selector (top).
// Assumes tick and reference strobes come from the clock domain of clk;
// a victim request samples counters as they stand before any same-cycle tick.
module age_replace_sel #(
    parameter int NUM_FRAMES = age_sel_pkg::DEF_FRAMES,
    parameter int AGE_W      = age_sel_pkg::DEF_AGE_W,
    parameter int IDX_W      = age_sel_pkg::idx_width(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FRAMES-1:0] ref_strb,
    input  logic                  tick,
    input  logic                  victim_req,
    output logic                  victim_vld,
    output logic [IDX_W-1:0]      victim_idx
);
    localparam int FLAT_W = NUM_FRAMES * AGE_W;

    logic [FLAT_W-1:0] ages_flat;
    logic [IDX_W-1:0]  min_idx;
    logic [AGE_W-1:0]  min_age;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_slot
        age_frame_slot #(.AGE_W(AGE_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_i  (ref_strb[g]),
            .tick_i (tick),
            .age_o  (ages_flat[g*AGE_W +: AGE_W])
        );
    end

    age_min_pick #(.NUM_FRAMES(NUM_FRAMES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ages_i    (ages_flat),
        .min_idx_o (min_idx),
        .min_age_o (min_age)
    );

    // Register the victim answer one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_vld <= 1'b0;
            victim_idx <= '0;
        end else begin
            victim_vld <= victim_req;
            if (victim_req) victim_idx <= min_idx;
        end
    end

    // R7
    vld_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_vld == $past(victim_req));
    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_vld |-> (int'(victim_idx) < NUM_FRAMES));
endmodule

// File: tb/age_replace_sel_tb.sv
// Scoreboard bench: the driver pushes expected victims, the monitor pops and compares.
module age_replace_sel_tb;
    localparam int NF = 6;
    localparam int AW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] ref_strb = '0;
    logic          tick = 1'b0;
    logic          victim_req = 1'b0;
    logic          victim_vld;
    logic [IW-1:0] victim_idx;

    int total = 0;
    int bad = 0;
    int    exp_q[$];
    string tag_q[$];

    logic [AW-1:0] m_age [NF];
    logic          m_r   [NF];

    always #5 clk = ~clk;

    age_replace_sel #(.NUM_FRAMES(NF), .AGE_W(AW), .IDX_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_strb(ref_strb), .tick(tick),
        .victim_req(victim_req), .victim_vld(victim_vld), .victim_idx(victim_idx)
    );

    function automatic int model_min();
        int best = 0;
        for (int k = 1; k < NF; k++) if (m_age[k] < m_age[best]) best = k;
        return best;
    endfunction

    // One cycle of stimulus; the model advances at the clock edge.
    task automatic step(input logic [NF-1:0] refs, input logic tk, input logic rq, input string tag);
        ref_strb = refs; tick = tk; victim_req = rq;
        if (rq) begin exp_q.push_back(model_min()); tag_q.push_back(tag); end
        @(posedge clk);
        for (int k = 0; k < NF; k++) begin
            if (tk) begin m_age[k] = {m_r[k], m_age[k][AW-1:1]}; m_r[k] = refs[k]; end
            else if (refs[k]) m_r[k] = 1'b1;
        end
        @(negedge clk);
        ref_strb = '0; tick = 1'b0; victim_req = 1'b0;
    endtask

    // Monitor: compare each valid result with the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && victim_vld) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R7 unexpected valid: actual idx=%0d expected none", victim_idx);
                end else begin
                    int e; string t;
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    if (int'(victim_idx) != e) begin
                        bad++;
                        $display("FAIL %s victim: actual=%0d expected=%0d", t, victim_idx, e);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NF-1:0] pat [5];
        pat[0] = 6'b110101; pat[1] = 6'b010011; pat[2] = 6'b101011;
        pat[3] = 6'b010001; pat[4] = 6'b000110;
        for (int k = 0; k < NF; k++) begin m_age[k] = '0; m_r[k] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: no valid before a request
        total++;
        if (victim_vld !== 1'b0) begin
            bad++; $display("FAIL R1 valid after reset: actual=%b expected=0", victim_vld);
        end
        step('0, 1'b0, 1'b1, "R1 reset state");
        // R1 / R2: references alone leave counters at zero (R8)
        step(6'b111110, 1'b0, 1'b0, "");
        step(6'b000000, 1'b0, 1'b1, "R8 no tick keeps counters");
        step(6'b111110, 1'b0, 1'b0, "R2 repeat strobe");
        step(6'b000000, 1'b1, 1'b0, "");
        step(6'b000000, 1'b0, 1'b1, "R2 flags enter on tick");
        // R4: decay for a full counter width without references
        for (int t = 0; t < AW; t++) step('0, 1'b1, 1'b0, "");
        step('0, 1'b0, 1'b1, "R4 decayed to zero tie");
        // R3 / R6: five-interval aging pattern on six frames
        for (int t = 0; t < 5; t++) begin
            step(pat[t], 1'b0, 1'b0, "");
            step('0, 1'b1, 1'b0, "");
            step('0, 1'b0, 1'b1, "R3 aging pattern");
        end
        // R5: reference together with tick waits for the next interval
        step(6'b000001, 1'b1, 1'b0, "");
        step('0, 1'b0, 1'b1, "R5 same-cycle ref unused by tick");
        step('0, 1'b1, 1'b1, "R7 request with tick samples pre-tick");
        step('0, 1'b0, 1'b1, "R5 ref applied at next tick");
        // R6: equal counters, lowest index wins
        for (int t = 0; t < AW; t++) step(6'b001100, 1'b1, 1'b0, "");
        step('0, 1'b1, 1'b0, "");
        step('0, 1'b0, 1'b1, "R6 tie picks lowest index");
        step(6'b000011, 1'b1, 1'b0, "");
        step('0, 1'b1, 1'b0, "");
        step('0, 1'b0, 1'b1, "R6 smallest counter");
        // R7: back-to-back requests
        step('0, 1'b0, 1'b1, "R7 back-to-back a");
        step('0, 1'b0, 1'b1, "R7 back-to-back b");
        step('0, 1'b0, 1'b0, "");
        total++;
        if (exp_q.size() != 0) begin
            bad++; $display("FAIL R7 missing results: actual=%0d pending expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule